// File: doc/BRIEF.md
# PC Card Strobe Timing Generator

This block times single accesses to a card area that is divided into two halves, called space A and space B. A host raises a request with a space-select bit and a read/write flag, and holds it. The block looks up the timing of the selected half in a 32-bit timing word: an access-type code, a delay from address to strobe, a strobe length and a delay from strobe release to address change. It then plays out the access on the card pins and answers with a one-cycle acknowledge.

The access type decides which pins move. I/O types use a dedicated read or write strobe and raise an I/O level for the whole access. Memory types use the output-enable or write-enable strobe. Attribute memory types also pull the register select low for the whole access. Every delay code follows a nonlinear mapping. The block converts each code to a cycle count once, when it accepts the request. From then on the access runs from counters and does not read the timing inputs again.

Top module: `pcc_strobe_gen`

## Requirements
- R1: After reset every strobe (`card_oe_n`, `card_we_n`, `card_iord_n`, `card_iowr_n`) and `card_reg_n` are high, and `card_io`, `card_act` and `ack` are low.
- R2: With `space_b` high the access uses the space B fields of `timing_word`: type in bits 27:24, extra wait in 21:20, wait in 19:16, setup in 11:8 and hold in 3:0. With `space_b` low it uses the space A fields: type in 31:28, extra wait in 23:22, setup in 15:12 and hold in 7:4, and its wait code comes from `base_wait`.
- R3: An access starts at the clock edge where `req` is seen high while the block is idle, and `card_act` rises at that edge. The strobe asserts S cycles later. S comes from the 3-bit setup code: codes 0 to 7 give 0, 1, 2, 3, 6, 9, 12 and 15 cycles.
- R4: After the strobe releases, `ack` goes high H cycles later. H is decoded from the 3-bit hold code with the same mapping as the setup code. `card_act` stays high until `ack` rises.
- R5: The strobe stays low for 1 + W + X cycles. W comes from the 4-bit wait code: codes 0 to 15 give 0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 11, 13, 15, 17, 21 and 25 cycles.
- R6: X comes from the 2-bit extra-wait code: codes 0, 1, 2 and 3 give 0, 15, 30 and 50 cycles.
- R7: Type codes 0 to 3 (ATA, dynamic I/O, 8-bit I/O, 16-bit I/O) strobe `card_iord_n` on a read or `card_iowr_n` on a write. `card_oe_n` and `card_we_n` stay high, and `card_io` is high for every cycle that `card_act` is high.
- R8: Type codes 4 to 7 strobe `card_oe_n` on a read or `card_we_n` on a write, and `card_io` stays low. Codes 6 and 7 (attribute memory) hold `card_reg_n` low for every cycle that `card_act` is high. Codes 4 and 5 (common memory) leave `card_reg_n` high.
- R9: `ack` is high for exactly one cycle per access, and `card_act` is low in that cycle. The block only takes a new request after the acknowledge.
- R10: The timing word, base wait, space select and write flag are sampled only at the edge that accepts a request. Changing them during an access does not change that access.
- R11: At most one of the four strobes is low in any cycle, and no strobe is low while `card_act` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until `ack` |
| space_b | input | 1 | 1 selects space B, 0 selects space A |
| wr | input | 1 | 1 for a write access, 0 for a read |
| timing_word | input | 32 | Per-space type, setup, wait, extra-wait and hold codes |
| base_wait | input | 4 | Wait code used by space A |
| ack | output | 1 | One-cycle access completion pulse |
| card_act | output | 1 | High from access start until the cycle before `ack` |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_we_n | output | 1 | Memory write strobe, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_reg_n | output | 1 | Attribute memory select, active low |
| card_io | output | 1 | High during I/O type accesses |

## Verification
The assertions check on every cycle that the strobes are mutually exclusive and never low outside an access, that the register select is low only during attribute accesses, that the acknowledge is a single pulse that follows an active access, and that the captured access type stays put during an access. Only the bench can show that the decoded cycle counts are right: the setup, strobe and hold lengths for each code and each space. It also shows that the right strobe pin is chosen for each type and direction, and that timing inputs changed during an access have no effect. For this it measures each of these lengths and pins against tables of its own, using directed extreme codes and seeded random words.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   // longest strobe: one base cycle + 25 wait + 50 extra
   localparam int unsigned PCC_MAX_STROBE = 1 + 25 + 50;
   localparam int unsigned PCC_MIN_CNT_W  = $clog2(PCC_MAX_STROBE + 1);

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_ACK    = 3'd4
   } pcc_state_e;

   // setup / hold code: 0..3 linear, then steps of three
   function automatic int unsigned pcc_edge_cycles(input logic [2:0] code);
      if (code < 3'd4) return int'(code);
      return 3 * int'(code) - 6;
   endfunction

   function automatic int unsigned pcc_extra_cycles(input logic [1:0] code);
      case (code)
         2'd0:    return 0;
         2'd1:    return 15;
         2'd2:    return 30;
         default: return 50;
      endcase
   endfunction

   // wait code: linear to 9, steps of two to 17, steps of four to 25
   function automatic int unsigned pcc_wait_cycles(input logic [3:0] code);
      if (code < 4'd10) return int'(code);
      if (code < 4'd14) return 2 * int'(code) - 9;
      return 4 * int'(code) - 35;
   endfunction

endpackage

// File: rtl/pcc_field_sel.sv
module pcc_field_sel
   import pcc_pkg::*;
#(
   parameter int TW_W    = 32,
   parameter int WCODE_W = 4,
   parameter int CNT_W   = 7
) (
   input  logic [TW_W-1:0]    timing_word,
   input  logic [WCODE_W-1:0] base_wait,
   input  logic               space_b,
   output logic [2:0]         sel_kind,
   output logic [CNT_W-1:0]   sel_setup,
   output logic [CNT_W-1:0]   sel_strobe,
   output logic [CNT_W-1:0]   sel_hold
);

   localparam int NSPACE = 2;

   logic [2:0]       kind_s   [NSPACE];
   logic [CNT_W-1:0] setup_s  [NSPACE];
   logic [CNT_W-1:0] strobe_s [NSPACE];
   logic [CNT_W-1:0] hold_s   [NSPACE];

   for (genvar s = 0; s < NSPACE; s++) begin : g_space
      localparam int TYPE_LSB  = 28 - 4 * s;
      localparam int XW_LSB    = 22 - 2 * s;
      localparam int SETUP_LSB = 12 - 4 * s;
      localparam int HOLD_LSB  = 4 - 4 * s;

      logic [3:0] wcode;
      if (s == 0) begin : g_wait_ext
         assign wcode = base_wait[3:0];
      end else begin : g_wait_word
         assign wcode = timing_word[19:16];
      end

      // type field is 4 bits wide; only 3 carry a defined code
      assign kind_s[s]   = timing_word[TYPE_LSB +: 3];
      assign setup_s[s]  = CNT_W'(pcc_edge_cycles(timing_word[SETUP_LSB +: 3]));
      assign hold_s[s]   = CNT_W'(pcc_edge_cycles(timing_word[HOLD_LSB +: 3]));
      assign strobe_s[s] = CNT_W'(1 + pcc_wait_cycles(wcode)
                                    + pcc_extra_cycles(timing_word[XW_LSB +: 2]));
   end

   assign sel_kind   = kind_s[space_b];
   assign sel_setup  = setup_s[space_b];
   assign sel_strobe = strobe_s[space_b];
   assign sel_hold   = hold_s[space_b];

   logic unused_bits;
   assign unused_bits = ^{timing_word[31], timing_word[27], base_wait};

endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
   import pcc_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr,
   input  logic [2:0]       in_kind,
   input  logic [CNT_W-1:0] in_setup,
   input  logic [CNT_W-1:0] in_strobe,
   input  logic [CNT_W-1:0] in_hold,
   output logic             ack,
   output logic             card_act,
   output logic             card_oe_n,
   output logic             card_we_n,
   output logic             card_iord_n,
   output logic             card_iowr_n,
   output logic             card_reg_n,
   output logic             card_io
);

   pcc_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       kind_q;
   logic             wr_q;
   logic [CNT_W-1:0] strobe_q;
   logic [CNT_W-1:0] hold_q;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         kind_q   <= '0;
         wr_q     <= 1'b0;
         strobe_q <= ONE;
         hold_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req) begin
               kind_q   <= in_kind;
               wr_q     <= wr;
               strobe_q <= in_strobe;
               hold_q   <= in_hold;
               if (in_setup != '0) begin
                  state <= ST_SETUP;
                  cnt   <= in_setup - ONE;
               end else begin
                  state <= ST_STROBE;
                  cnt   <= in_strobe - ONE;
               end
            end
            ST_SETUP: begin
               if (cnt == '0) begin
                  state <= ST_STROBE;
                  cnt   <= strobe_q - ONE;
               end else begin
                  cnt <= cnt - ONE;
               end
            end
            ST_STROBE: begin
               if (cnt != '0) begin
                  cnt <= cnt - ONE;
               end else if (hold_q != '0) begin
                  state <= ST_HOLD;
                  cnt   <= hold_q - ONE;
               end else begin
                  state <= ST_ACK;
               end
            end
            ST_HOLD: begin
               if (cnt == '0) state <= ST_ACK;
               else           cnt   <= cnt - ONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic in_strobe_ph;
   logic is_io;
   logic is_attr;

   assign in_strobe_ph = (state == ST_STROBE);
   assign is_io        = ~kind_q[2];
   assign is_attr      = kind_q[2] & kind_q[1];

   assign card_act    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
   assign ack         = (state == ST_ACK);
   assign card_oe_n   = ~(in_strobe_ph & ~is_io & ~wr_q);
   assign card_we_n   = ~(in_strobe_ph & ~is_io &  wr_q);
   assign card_iord_n = ~(in_strobe_ph &  is_io & ~wr_q);
   assign card_iowr_n = ~(in_strobe_ph &  is_io &  wr_q);
   assign card_reg_n  = ~(card_act & is_attr);
   assign card_io     = card_act & is_io;

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n}));

   // R11
   strobe_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!card_oe_n || !card_we_n || !card_iord_n || !card_iowr_n) |-> card_act);

   // R9
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R9
   ack_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(card_act));

   // R8
   reg_attr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !card_reg_n |-> (card_act && card_io == 1'b0));

   // R10
   kind_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_act && $past(card_act)) |-> ($stable(kind_q) && $stable(wr_q)));

endmodule

// File: rtl/pcc_strobe_gen.sv
module pcc_strobe_gen
   import pcc_pkg::*;
#(
   parameter int TW_W    = 32,
   parameter int WCODE_W = 4,
   parameter int CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic               space_b,
   input  logic               wr,
   input  logic [TW_W-1:0]    timing_word,
   input  logic [WCODE_W-1:0] base_wait,
   output logic               ack,
   output logic               card_act,
   output logic               card_oe_n,
   output logic               card_we_n,
   output logic               card_iord_n,
   output logic               card_iowr_n,
   output logic               card_reg_n,
   output logic               card_io
);

   if (TW_W != 32) begin : g_bad_tw
      $error("pcc_strobe_gen: timing word must be 32 bits");
   end
   if (WCODE_W != 4) begin : g_bad_wcode
      $error("pcc_strobe_gen: wait code must be 4 bits");
   end
   if (CNT_W < int'(PCC_MIN_CNT_W)) begin : g_bad_cnt
      $error("pcc_strobe_gen: counter too narrow for longest strobe");
   end

   logic [2:0]       sel_kind;
   logic [CNT_W-1:0] sel_setup;
   logic [CNT_W-1:0] sel_strobe;
   logic [CNT_W-1:0] sel_hold;

   pcc_field_sel #(
      .TW_W    (TW_W),
      .WCODE_W (WCODE_W),
      .CNT_W   (CNT_W)
   ) u_fields (
      .timing_word (timing_word),
      .base_wait   (base_wait),
      .space_b     (space_b),
      .sel_kind    (sel_kind),
      .sel_setup   (sel_setup),
      .sel_strobe  (sel_strobe),
      .sel_hold    (sel_hold)
   );

   pcc_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (req),
      .wr          (wr),
      .in_kind     (sel_kind),
      .in_setup    (sel_setup),
      .in_strobe   (sel_strobe),
      .in_hold     (sel_hold),
      .ack         (ack),
      .card_act    (card_act),
      .card_oe_n   (card_oe_n),
      .card_we_n   (card_we_n),
      .card_iord_n (card_iord_n),
      .card_iowr_n (card_iowr_n),
      .card_reg_n  (card_reg_n),
      .card_io     (card_io)
   );

endmodule

// File: tb/pcc_strobe_gen_test.sv
`timescale 1ns/1ps
module pcc_strobe_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        space_b = 1'b0;
   logic        wr = 1'b0;
   logic [31:0] timing_word = '0;
   logic [3:0]  base_wait = '0;
   logic        ack, card_act, card_oe_n, card_we_n;
   logic        card_iord_n, card_iowr_n, card_reg_n, card_io;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pcc_strobe_gen uut (
      .clk(clk), .rst_n(rst_n), .req(req), .space_b(space_b), .wr(wr),
      .timing_word(timing_word), .base_wait(base_wait), .ack(ack),
      .card_act(card_act), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
      .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n),
      .card_reg_n(card_reg_n), .card_io(card_io)
   );

   int edge_tab [8]  = '{0, 1, 2, 3, 6, 9, 12, 15};
   int xw_tab   [4]  = '{0, 15, 30, 50};
   int wait_tab [16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 11, 13, 15, 17, 21, 25};

   task automatic check(input string tag, input int actual, input int expected);
      checks++;
      if (actual !== expected) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic run_access(input logic sb, input logic w, input logic [31:0] tw,
                             input logic [3:0] bw, input bit disturb);
      int s, l, h, kind, first_k, slen, ack_k, io_n, reg_n_lo, act_n;
      int mask, exp_mask;
      s    = sb ? edge_tab[tw[10:8]] : edge_tab[tw[14:12]];
      h    = sb ? edge_tab[tw[2:0]]  : edge_tab[tw[6:4]];
      l    = 1 + (sb ? wait_tab[tw[19:16]] : wait_tab[bw]) +
                 (sb ? xw_tab[tw[21:20]] : xw_tab[tw[23:22]]);
      kind = sb ? int'(tw[26:24]) : int'(tw[30:28]);
      exp_mask = (kind < 4) ? (w ? 8 : 4) : (w ? 2 : 1);
      first_k = -1; slen = 0; ack_k = -1; io_n = 0; reg_n_lo = 0; act_n = 0; mask = 0;
      @(negedge clk);
      space_b = sb; wr = w; timing_word = tw; base_wait = bw; req = 1'b1;
      for (int k = 1; k < 400; k++) begin
         @(negedge clk);
         if (disturb && k == 2) begin
            timing_word = ~tw; base_wait = ~bw; space_b = ~sb; wr = ~w;
         end
         if (!card_oe_n)   mask |= 1;
         if (!card_we_n)   mask |= 2;
         if (!card_iord_n) mask |= 4;
         if (!card_iowr_n) mask |= 8;
         if (!(card_oe_n && card_we_n && card_iord_n && card_iowr_n)) begin
            if (first_k < 0) first_k = k;
            slen++;
         end
         if (card_io) io_n++;
         if (!card_reg_n) reg_n_lo++;
         if (card_act) act_n++;
         if (ack) begin
            ack_k = k;
            req = 1'b0;
            break;
         end
      end
      // R3 setup length, R2 field choice
      check("R3/R2 strobe start", first_k, s + 1);
      // R5 R6 strobe width
      check("R5/R6 strobe width", slen, l);
      // R4 hold before ack
      check("R4 ack position", ack_k, s + l + h + 1);
      // R7 R8 pin selection
      check("R7/R8 strobe pin mask", mask, exp_mask);
      // R7 io level
      check("R7 io level cycles", io_n, (kind < 4) ? s + l + h : 0);
      // R8 attribute select
      check("R8 reg select cycles", reg_n_lo, (kind >= 6) ? s + l + h : 0);
      check("R4 act cycles", act_n, s + l + h);
      @(negedge clk);
      // R9 single ack and return to idle
      check("R9 ack drops", int'(ack), 0);
      check("R9 idle after ack", int'(card_act), 0);
      if (disturb) check("R10 disturbed access ran on captured values", ack_k, s + l + h + 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 oe_n", int'(card_oe_n), 1);
      check("R1 we_n", int'(card_we_n), 1);
      check("R1 iord_n/iowr_n", int'(card_iord_n & card_iowr_n), 1);
      check("R1 reg_n", int'(card_reg_n), 1);
      check("R1 io/act/ack", int'({card_io, card_act, ack}), 0);
      rst_n = 1'b1;
      // R3 R4 R5 minimum codes
      run_access(1'b0, 1'b0, 32'h4000_0000, 4'd0, 1'b0);
      // R6 R5 maximum codes, space B, attribute write
      run_access(1'b1, 1'b1, 32'h073F_0707, 4'd0, 1'b0);
      // R2 space A with extreme base wait, 8-bit I/O read
      run_access(1'b0, 1'b0, 32'h20C0_7070, 4'd15, 1'b0);
      // R7 ATA write on space B
      run_access(1'b1, 1'b1, 32'h7000_0304, 4'd9, 1'b0);
      // R8 common memory write space A
      run_access(1'b0, 1'b1, 32'h5880_4050, 4'd13, 1'b0);
      // R10 inputs changed mid access
      run_access(1'b1, 1'b0, 32'h1625_0302, 4'd3, 1'b1);
      for (int i = 0; i < 40; i++) begin
         logic [31:0] tw;
         logic [3:0]  bw;
         tw = $urandom;
         bw = 4'($urandom);
         run_access(1'($urandom), 1'($urandom), tw, bw, (i % 3) == 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule